// File: doc/BRIEF.md
# Ternary Flow Classification Table

This block holds a small table of ternary entries, each made of a key, a mask, a valid bit and an action word. A classification key presented with a strobe is compared against every valid entry at once. A mask bit of one makes the matching key bit a don't-care, and a mask bit of zero requires that bit to be equal. The lowest-numbered matching entry supplies the result one clock later. The action word either spreads the flow over four listed DMA channels by source hash or marks it for discard. The key builder, the hash unit and the DMA engines sit outside the block.

A configuration side writes key, mask and action into one location, clears every valid bit with a single command, and reads any location back combinationally. A global enable input gates all lookups. Typical software brings the table up with the enable low, invalidates everything, and then installs an entry whose mask is cleared only over an identifier field (for example a blade number) and set everywhere else. That entry catches all traffic of that identifier and spreads it by source hash.

Top module: `tcam_classifier`

## Requirements
- R1: After reset every entry is invalid, reads back key all zeros and mask all ones, and holds the default action 0x1E4 (spread by source hash over channels d=0, c=1, b=2, a=3, discard clear). The result outputs are all zero.
- R2: A valid entry matches when every key bit whose mask bit is 0 equals the lookup key bit. Mask bits of 1 are ignored, so an all-ones mask matches any key.
- R3: When several valid entries match, the lowest index is reported.
- R4: A lookup that matches no valid entry returns hit=0, index 0 and every action output at zero.
- R5: While the enable input is low, every lookup returns a miss as in R4, whatever the table holds.
- R6: The result of a lookup strobed in cycle t appears on the result outputs after the clock edge that ends cycle t. res_valid is high for exactly that one cycle, and the result outputs keep their value until the next strobe.
- R7: A write in cycle t updates the entry for lookups strobed from cycle t+1 on. A lookup strobed in the same cycle as the write sees the old contents.
- R8: Invalidate-all clears every valid bit in one cycle. A write issued in the same cycle stores its key, mask and action, but the entry stays invalid.
- R9: The read port returns the key, mask, action and valid bit of the addressed location combinationally, reflecting all writes up to the last clock edge.
- R10: The action word is laid out as bit 9 discard, bit 8 source-hash select, bits 7:6 channel a, 5:4 channel b, 3:2 channel c and 1:0 channel d. A hit drives these fields onto the matching result outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lookup_en | input | 1 | Global lookup enable |
| cfg_wr | input | 1 | Write strobe for one entry |
| cfg_addr | input | 3 | Entry written |
| cfg_key | input | 16 | Key to store |
| cfg_mask | input | 16 | Mask to store (1 = don't care) |
| cfg_act | input | 10 | Action word to store |
| cfg_inv_all | input | 1 | Clear all valid bits |
| rd_addr | input | 3 | Entry to read back |
| rd_key | output | 16 | Stored key at rd_addr |
| rd_mask | output | 16 | Stored mask at rd_addr |
| rd_act | output | 10 | Stored action at rd_addr |
| rd_valid | output | 1 | Valid bit at rd_addr |
| lk_valid | input | 1 | Lookup strobe |
| lk_key | input | 16 | Lookup key |
| res_valid | output | 1 | Result strobe, one cycle after lk_valid |
| res_hit | output | 1 | A valid entry matched |
| res_index | output | 3 | Index of the winning entry |
| res_discard | output | 1 | Discard flag of the winner |
| res_hash_sel | output | 1 | Source-hash select of the winner |
| res_ch_a | output | 2 | Channel a |
| res_ch_b | output | 2 | Channel b |
| res_ch_c | output | 2 | Channel c |
| res_ch_d | output | 2 | Channel d |

## Verification
A table update and a lookup can fall in the same cycle. So can an invalidate-all and a write to the same table. The bench drives writes, invalidates and lookup strobes from independent random draws, so all three often land together. Directed steps also force a write and a lookup of the same key in one cycle, and a write together with an invalidate. The bench model takes the lookup result from the table as it stood before the edge and only then applies the update, with invalidate overriding the new entry's valid bit. Any design that forwards a same-cycle write into a lookup, or that lets such a write survive the invalidate, produces a miscompare.

// File: rtl/tcam_cls_pkg.sv
package tcam_cls_pkg;
    localparam int CH_W = 2;

    typedef struct packed {
        logic            discard;
        logic            hash_sel;
        logic [CH_W-1:0] ch_a;
        logic [CH_W-1:0] ch_b;
        logic [CH_W-1:0] ch_c;
        logic [CH_W-1:0] ch_d;
    } act_t;

    localparam int ACT_W = $bits(act_t);

    localparam act_t DEFAULT_ACT = '{discard: 1'b0, hash_sel: 1'b1,
                                     ch_a: 2'd3, ch_b: 2'd2,
                                     ch_c: 2'd1, ch_d: 2'd0};
endpackage

// File: rtl/tcam_cls_store.sv
module tcam_cls_store
    import tcam_cls_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int KEY_W   = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr,
    input  logic [IDX_W-1:0]                wr_addr,
    input  logic [KEY_W-1:0]                wr_key,
    input  logic [KEY_W-1:0]                wr_mask,
    input  act_t                            wr_act,
    input  logic                            inv_all,
    output logic [ENTRIES-1:0][KEY_W-1:0]   key_o,
    output logic [ENTRIES-1:0][KEY_W-1:0]   mask_o,
    output act_t [ENTRIES-1:0]              act_o,
    output logic [ENTRIES-1:0]              vld_o
);
    typedef struct packed {
        logic [ENTRIES-1:0][KEY_W-1:0] key;
        logic [ENTRIES-1:0][KEY_W-1:0] mask;
        act_t [ENTRIES-1:0]            act;
        logic [ENTRIES-1:0]            vld;
    } tbl_t;

    tbl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.key[wr_addr]  = wr_key;
            st_d.mask[wr_addr] = wr_mask;
            st_d.act[wr_addr]  = wr_act;
            st_d.vld[wr_addr]  = 1'b1;
        end
        if (inv_all) begin
            st_d.vld = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.key  <= '0;
            st_q.mask <= '1;
            st_q.vld  <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                st_q.act[i] <= DEFAULT_ACT;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign key_o  = st_q.key;
    assign mask_o = st_q.mask;
    assign act_o  = st_q.act;
    assign vld_o  = st_q.vld;

    AST_INV_CLEARS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (vld_o == '0)); // R8
    AST_WRITE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !inv_all) |=> vld_o[$past(wr_addr)]); // R7
endmodule

// File: rtl/tcam_cls_match.sv
module tcam_cls_match #(
    parameter int ENTRIES = 8,
    parameter int KEY_W   = 16
) (
    input  logic [KEY_W-1:0]              key,
    input  logic [ENTRIES-1:0][KEY_W-1:0] ent_key,
    input  logic [ENTRIES-1:0][KEY_W-1:0] ent_mask,
    input  logic [ENTRIES-1:0]            ent_vld,
    input  logic                          enable,
    output logic [ENTRIES-1:0]            hits
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_row
        logic [KEY_W-1:0] diff;
        assign diff    = (key ^ ent_key[g]) & ~ent_mask[g];
        assign hits[g] = enable && ent_vld[g] && (diff == '0);
    end
endmodule

// File: rtl/tcam_cls_pick.sv
module tcam_cls_pick #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] hits,
    output logic               any,
    output logic [IDX_W-1:0]   idx,
    output logic [ENTRIES-1:0] grant
);
    always_comb begin
        idx   = '0;
        grant = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hits[i]) begin
                idx   = IDX_W'(i);
                grant = ENTRIES'(1) << i;
            end
        end
        any = |hits;
    end

    always_comb begin
        AST_GRANT_ONEHOT: assert ($onehot0(grant)); // R3
        AST_GRANT_IN_HITS: assert ((grant & ~hits) == '0); // R3
        AST_GRANT_LOWEST: assert (!any || ((hits & (grant - ENTRIES'(1))) == '0)); // R3
    end
endmodule

// File: rtl/tcam_classifier.sv
module tcam_classifier
    import tcam_cls_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int KEY_W   = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lookup_en,
    input  logic                 cfg_wr,
    input  logic [IDX_W-1:0]     cfg_addr,
    input  logic [KEY_W-1:0]     cfg_key,
    input  logic [KEY_W-1:0]     cfg_mask,
    input  logic [ACT_W-1:0]     cfg_act,
    input  logic                 cfg_inv_all,
    input  logic [IDX_W-1:0]     rd_addr,
    output logic [KEY_W-1:0]     rd_key,
    output logic [KEY_W-1:0]     rd_mask,
    output logic [ACT_W-1:0]     rd_act,
    output logic                 rd_valid,
    input  logic                 lk_valid,
    input  logic [KEY_W-1:0]     lk_key,
    output logic                 res_valid,
    output logic                 res_hit,
    output logic [IDX_W-1:0]     res_index,
    output logic                 res_discard,
    output logic                 res_hash_sel,
    output logic [CH_W-1:0]      res_ch_a,
    output logic [CH_W-1:0]      res_ch_b,
    output logic [CH_W-1:0]      res_ch_c,
    output logic [CH_W-1:0]      res_ch_d
);
    typedef struct packed {
        logic             vld;
        logic             hit;
        logic [IDX_W-1:0] idx;
        act_t             act;
    } res_t;

    logic [ENTRIES-1:0][KEY_W-1:0] ent_key;
    logic [ENTRIES-1:0][KEY_W-1:0] ent_mask;
    act_t [ENTRIES-1:0]            ent_act;
    logic [ENTRIES-1:0]            ent_vld;
    logic [ENTRIES-1:0]            hits;
    logic [ENTRIES-1:0]            grant;
    logic                          any_hit;
    logic [IDX_W-1:0]              win_idx;
    res_t                          res_d, res_q;

    tcam_cls_store #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cfg_wr),
        .wr_addr (cfg_addr),
        .wr_key  (cfg_key),
        .wr_mask (cfg_mask),
        .wr_act  (act_t'(cfg_act)),
        .inv_all (cfg_inv_all),
        .key_o   (ent_key),
        .mask_o  (ent_mask),
        .act_o   (ent_act),
        .vld_o   (ent_vld)
    );

    tcam_cls_match #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_match (
        .key      (lk_key),
        .ent_key  (ent_key),
        .ent_mask (ent_mask),
        .ent_vld  (ent_vld),
        .enable   (lookup_en),
        .hits     (hits)
    );

    tcam_cls_pick #(.ENTRIES(ENTRIES)) u_pick (
        .hits  (hits),
        .any   (any_hit),
        .idx   (win_idx),
        .grant (grant)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = lk_valid;
        if (lk_valid) begin
            res_d.hit = any_hit;
            res_d.idx = any_hit ? win_idx : '0;
            res_d.act = any_hit ? ent_act[win_idx] : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign rd_key       = ent_key[rd_addr];
    assign rd_mask      = ent_mask[rd_addr];
    assign rd_act       = ent_act[rd_addr];
    assign rd_valid     = ent_vld[rd_addr];

    assign res_valid    = res_q.vld;
    assign res_hit      = res_q.hit;
    assign res_index    = res_q.idx;
    assign res_discard  = res_q.act.discard;
    assign res_hash_sel = res_q.act.hash_sel;
    assign res_ch_a     = res_q.act.ch_a;
    assign res_ch_b     = res_q.act.ch_b;
    assign res_ch_c     = res_q.act.ch_c;
    assign res_ch_d     = res_q.act.ch_d;

    AST_RESULT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid); // R6
    AST_RESULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!res_valid && $stable(res_index) && $stable(res_hit))); // R6
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_index == '0 && !res_discard && !res_hash_sel
            && res_ch_a == '0 && res_ch_b == '0 && res_ch_c == '0 && res_ch_d == '0)); // R4
    AST_DISABLED_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lookup_en) |=> !res_hit); // R5
    AST_HIT_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && ent_vld == '0) |=> !res_hit); // R2
endmodule

// File: tb/tb_tcam_classifier.sv
`timescale 1ns/1ps
module tb_tcam_classifier;
    localparam int N = 8;
    localparam int KW = 16;
    localparam int AW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          lookup_en, cfg_wr, cfg_inv_all, lk_valid;
    logic [2:0]    cfg_addr, rd_addr;
    logic [KW-1:0] cfg_key, cfg_mask, lk_key;
    logic [AW-1:0] cfg_act;
    logic [KW-1:0] rd_key, rd_mask;
    logic [AW-1:0] rd_act;
    logic          rd_valid, res_valid, res_hit, res_discard, res_hash_sel;
    logic [2:0]    res_index;
    logic [1:0]    res_ch_a, res_ch_b, res_ch_c, res_ch_d;

    tcam_classifier dut (
        .clk(clk), .rst_n(rst_n), .lookup_en(lookup_en),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_key(cfg_key),
        .cfg_mask(cfg_mask), .cfg_act(cfg_act), .cfg_inv_all(cfg_inv_all),
        .rd_addr(rd_addr), .rd_key(rd_key), .rd_mask(rd_mask),
        .rd_act(rd_act), .rd_valid(rd_valid),
        .lk_valid(lk_valid), .lk_key(lk_key),
        .res_valid(res_valid), .res_hit(res_hit), .res_index(res_index),
        .res_discard(res_discard), .res_hash_sel(res_hash_sel),
        .res_ch_a(res_ch_a), .res_ch_b(res_ch_b),
        .res_ch_c(res_ch_c), .res_ch_d(res_ch_d)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [KW-1:0] m_key [N];
    logic [KW-1:0] m_mask[N];
    logic [AW-1:0] m_act [N];
    logic          m_vld [N];
    logic          e_rv, e_hit;
    logic [2:0]    e_idx;
    logic [AW-1:0] e_act;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic hit_of(input int i, input logic [KW-1:0] k);
        return m_vld[i] && (((k ^ m_key[i]) & ~m_mask[i]) == '0);
    endfunction

    task automatic idle();
        cfg_wr = 0; cfg_inv_all = 0; lk_valid = 0;
    endtask

    // Drive at a falling edge, check read port and next-cycle result.
    task automatic cycle(input string tag);
        logic [AW-1:0] a;
        #1;
        chk(rd_key == m_key[rd_addr] && rd_mask == m_mask[rd_addr] &&
            rd_act == m_act[rd_addr] && rd_valid == m_vld[rd_addr],
            "R9 readback", {rd_valid, rd_act, rd_key[4:0]},
            {m_vld[rd_addr], m_act[rd_addr], m_key[rd_addr][4:0]});
        e_rv = lk_valid;
        if (lk_valid) begin
            e_hit = 0; e_idx = 0; e_act = 0;
            if (lookup_en) begin
                for (int i = N - 1; i >= 0; i--) begin
                    if (hit_of(i, lk_key)) begin
                        e_hit = 1; e_idx = 3'(i); e_act = m_act[i];
                    end
                end
            end
        end
        if (cfg_wr) begin
            m_key[cfg_addr] = cfg_key; m_mask[cfg_addr] = cfg_mask;
            m_act[cfg_addr] = cfg_act; m_vld[cfg_addr] = 1'b1;
        end
        if (cfg_inv_all) for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
        @(negedge clk);
        a = {res_discard, res_hash_sel, res_ch_a, res_ch_b, res_ch_c, res_ch_d};
        chk(res_valid == e_rv, {tag, " R6 strobe"}, 32'(res_valid), 32'(e_rv));
        chk(res_hit == e_hit && res_index == e_idx, {tag, " R3 hit/index"},
            {res_hit, res_index}, {e_hit, e_idx});
        chk(a == e_act, {tag, " R10 action"}, 32'(a), 32'(e_act));
    endtask

    task automatic wr(input int ad, input logic [KW-1:0] k, input logic [KW-1:0] m, input logic [AW-1:0] ac);
        cfg_wr = 1; cfg_addr = 3'(ad); cfg_key = k; cfg_mask = m; cfg_act = ac;
    endtask

    task automatic lk(input logic [KW-1:0] k);
        lk_valid = 1; lk_key = k;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00c0ffee));
        for (int i = 0; i < N; i++) begin
            m_key[i] = '0; m_mask[i] = '1; m_act[i] = 10'h1E4; m_vld[i] = 0;
        end
        e_rv = 0; e_hit = 0; e_idx = 0; e_act = 0;
        idle(); lookup_en = 1; cfg_addr = 0; cfg_key = 0; cfg_mask = 0;
        cfg_act = 0; lk_key = 0; rd_addr = 0;
        repeat (3) @(negedge clk);
        // R1: reset state on every location and on the result outputs
        for (int i = 0; i < N; i++) begin
            rd_addr = 3'(i); #1;
            chk(rd_key == 0 && rd_mask == 16'hFFFF && rd_act == 10'h1E4 && !rd_valid,
                "R1 reset entry", {rd_valid, rd_act, rd_mask}, {1'b0, 10'h1E4, 16'hFFFF});
        end
        chk({res_valid, res_hit, res_index, res_discard, res_hash_sel, res_ch_a,
             res_ch_b, res_ch_c, res_ch_d} == '0, "R1 reset result", 32'(res_hit), 0);
        rst_n = 1;
        @(negedge clk);
        // R4: empty table misses
        lk(16'h1234); cycle("R4 empty"); idle();
        // R7: write and lookup in the same cycle sees old contents
        wr(5, 16'h0000, 16'hFFFF, 10'h1E4); lk(16'hABCD); cycle("R7 same-cycle"); idle();
        lk(16'hABCD); cycle("R7 next-cycle"); idle();
        // R3: entries 2 and 5 both match, lowest wins
        wr(2, 16'h0300, 16'h00FF, 10'h2A5); cycle("R3 setup"); idle();
        lk(16'h03EE); cycle("R3 two hits"); idle();
        // R2: exact field (high byte) mismatch falls to entry 5
        lk(16'h0400); cycle("R2 field mismatch"); idle();
        // R5: disable gates all lookups
        lookup_en = 0; lk(16'h03EE); cycle("R5 disabled"); idle(); lookup_en = 1;
        // R6: no strobe keeps outputs
        rd_addr = 2; cycle("R6 hold");
        // R8: invalidate together with a write
        cfg_inv_all = 1; wr(1, 16'h0001, 16'h0000, 10'h3FF); lk(16'h0001);
        rd_addr = 1; cycle("R8 inv+wr"); idle();
        lk(16'h0001); cycle("R8 after inv"); idle();
        // constrained random mix
        for (int n = 0; n < 4000; n++) begin
            logic [KW-1:0] masks [5];
            masks[0] = 16'hFFFF; masks[1] = 16'hFF00; masks[2] = 16'h00FF;
            masks[3] = 16'h0000; masks[4] = 16'hFFF0;
            cfg_wr      = ($urandom_range(0, 3) == 0);
            cfg_inv_all = ($urandom_range(0, 40) == 0);
            cfg_addr    = 3'($urandom_range(0, N - 1));
            cfg_key     = 16'($urandom_range(0, 7)) * 16'h1111;
            cfg_mask    = masks[$urandom_range(0, 4)];
            cfg_act     = 10'($urandom);
            lk_valid    = ($urandom_range(0, 2) != 0);
            lk_key      = 16'($urandom_range(0, 7)) * 16'h1111 ^ 16'($urandom_range(0, 1));
            lookup_en   = ($urandom_range(0, 15) != 0);
            rd_addr     = 3'($urandom_range(0, N - 1));
            cycle("random");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule